// File: doc/BRIEF.md
# Greedy Weight-Matrix Crossbar Scheduler

This block chooses which input-output pairs of an N×N crossbar are connected in one cell slot. It receives a binary request matrix in which bit (i,j) says that input i holds a cell for output j. Each request gets a weight. The weight is the reciprocal of the number of requests in that request's row, plus the reciprocal of the number of requests in its column. A request that competes with few others therefore scores high.

On every clock the block takes the request with the greatest weight. It then deletes that request's whole row and column from its working copy of the matrix and recomputes all weights on what remains. This repeats until no request is left. Each chosen pair is output on a strobe, in the order it was chosen, and a done pulse follows the last pair. Weights are held as exact integers, scaled by the least common multiple of 1..N, so two weights are never mistaken for equal or unequal. The block gives no protection against starvation: a request that always loses to less contested neighbours can be passed over indefinitely.

Top module: `greedy_match_sched`

## Requirements
- R1: Bit i*N+j of `req_mtx` is 1 when input i requests output j. `req_mtx` is captured on the rising clock edge at which `start` is high while the block is idle.
- R2: A remaining request (i,j) has weight L/r(i) + L/c(j), where r(i) and c(j) are the request counts of row i and column j in the remaining matrix and L is the least common multiple of 1..N (12 for N=4). Every such weight lies between 2·L/N and 2·L.
- R3: Each step picks a remaining request of greatest weight. It then removes every request in that request's row and column, and the next step recomputes the weights on the reduced matrix.
- R4: When several requests share the greatest weight, the one with the lowest input index is picked; if the input index is also shared, the one with the lowest output index.
- R5: The k-th pick (k from 1) appears with `sel_valid` high in the clock cycle that starts k rising edges after the capturing edge, with `sel_step` equal to k-1.
- R6: `done` is high for exactly one cycle, in the cycle right after the last pick; it is never high together with `sel_valid`. For an all-zero matrix, `done` rises one edge after the capturing edge and no pick is output.
- R7: The picks of one run form a maximal matching. No input or output index appears twice, and no original request has both its input and its output left unpicked.
- R8: `start` and `req_mtx` are ignored from the capturing edge up to and including the edge that raises `done`; the sequence of picks is unaffected.
- R9: After reset, `sel_valid` and `done` are low and the block is idle.
- R10: Two example matrices give fixed results. The matrix with requests (0,1),(0,2),(1,0),(2,3),(3,0),(3,2) yields the picks (2,3),(0,1),(1,0),(3,2) in that order. The matrix with requests (0,0),(1,0),(1,1) yields (0,0),(1,1), so (1,0) is never granted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a scheduling run with `req_mtx` (used only when idle) |
| req_mtx | input | N*N | Request matrix, bit i*N+j = input i wants output j |
| sel_valid | output | 1 | A picked pair is presented this cycle |
| sel_in | output | clog2(N) | Input index of the picked pair |
| sel_out | output | clog2(N) | Output index of the picked pair |
| sel_step | output | clog2(N) | Position of this pick in the run, from 0 |
| done | output | 1 | One-cycle pulse after the last pick of a run |

## Verification
Random request matrices of several densities are compared with a reference model. The model ranks requests by cross-multiplying the row and column counts instead of using scaled reciprocals, so it catches errors in the reciprocal table and in the recomputation after each deletion. Directed cases cover the following:
- The full matrix, in which every weight ties, exposes the tie-break order.
- The empty matrix and a single request expose the timing of `done`.
- The two example matrices pin the expected picks, including the starved request.
- A run with `start` pulsed in the middle, while the block is busy, shows that the second request is ignored.

// File: rtl/gms_pkg.sv
package gms_pkg;

  function automatic int gcd_int(input int a, input int b);
    int x;
    int y;
    int t;
    x = a;
    y = b;
    while (y != 0) begin
      t = x % y;
      x = y;
      y = t;
    end
    return x;
  endfunction

  // Least common multiple of all integers 1..n: the weight scale.
  function automatic int lcm_upto(input int n);
    int l;
    l = 1;
    for (int k = 2; k <= n; k++) begin
      l = (l / gcd_int(l, k)) * k;
    end
    return l;
  endfunction

  function automatic int bits_for(input int v);
    return (v < 2) ? 1 : $clog2(v);
  endfunction

endpackage

// File: rtl/gms_occupancy.sv
module gms_occupancy #(
  parameter int N  = 4,
  parameter int CW = 3
) (
  input  logic [N*N-1:0] mtx,
  output logic [CW-1:0]  row_cnt [N],
  output logic [CW-1:0]  col_cnt [N]
);
  for (genvar i = 0; i < N; i++) begin : g_row
    always_comb begin
      row_cnt[i] = '0;
      for (int j = 0; j < N; j++) row_cnt[i] = row_cnt[i] + CW'(mtx[i*N+j]);
    end
  end

  for (genvar j = 0; j < N; j++) begin : g_col
    always_comb begin
      col_cnt[j] = '0;
      for (int i = 0; i < N; i++) col_cnt[j] = col_cnt[j] + CW'(mtx[i*N+j]);
    end
  end
endmodule

// File: rtl/gms_weight_array.sv
module gms_weight_array #(
  parameter int N   = 4,
  parameter int CW  = 3,
  parameter int LCM = 12,
  parameter int RW  = 4,
  parameter int WW  = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N*N-1:0] mtx,
  input  logic [CW-1:0]  row_cnt [N],
  input  logic [CW-1:0]  col_cnt [N],
  output logic [WW-1:0]  wgt     [N*N]
);
  localparam int TBL = 1 << CW;

  // Reciprocal table: entry k holds LCM/k, so sums stay exact integers.
  logic [RW-1:0] recip [TBL];
  for (genvar k = 0; k < TBL; k++) begin : g_recip
    if (k == 0 || k > N) begin : g_zero
      assign recip[k] = '0;
    end else begin : g_val
      assign recip[k] = RW'(LCM / k);
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_i
    for (genvar j = 0; j < N; j++) begin : g_j
      assign wgt[i*N+j] = mtx[i*N+j]
                          ? (WW'(recip[row_cnt[i]]) + WW'(recip[col_cnt[j]]))
                          : '0;

      assert_weight_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mtx[i*N+j] |-> (wgt[i*N+j] >= WW'(2 * (LCM / N)) && wgt[i*N+j] <= WW'(2 * LCM)));
    end
  end
endmodule

// File: rtl/gms_argmax.sv
module gms_argmax #(
  parameter int N  = 4,
  parameter int IW = 2,
  parameter int WW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [WW-1:0] wgt [N*N],
  output logic          found,
  output logic [IW-1:0] best_row,
  output logic [IW-1:0] best_col
);
  localparam int NN = N * N;
  localparam int FW = (NN < 2) ? 1 : $clog2(NN);

  logic [WW-1:0] best_w;
  logic [FW-1:0] best_flat;

  // Row-major scan with strict comparison: the earliest (lowest row, then
  // lowest column) cell keeps a tie.
  always_comb begin
    best_w    = '0;
    best_flat = '0;
    for (int k = 0; k < NN; k++) begin
      if (wgt[k] > best_w) begin
        best_w    = wgt[k];
        best_flat = FW'(k);
      end
    end
  end

  assign found    = (best_w != '0);
  assign best_row = IW'(best_flat / FW'(N));
  assign best_col = IW'(best_flat % FW'(N));

  for (genvar k = 0; k < NN; k++) begin : g_chk
    assert_best_dominates_R3: assert property (@(posedge clk) disable iff (!rst_n)
      found |-> (wgt[k] <= wgt[best_row*N + best_col]));
    assert_tie_lowest_index_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (found && wgt[k] == wgt[best_row*N + best_col]) |-> (k >= best_row*N + best_col));
    assert_none_when_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !found |-> (wgt[k] == '0));
  end
endmodule

// File: rtl/greedy_match_sched.sv
module greedy_match_sched #(
  parameter int N  = 4,
  parameter int IW = gms_pkg::bits_for(N)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [N*N-1:0] req_mtx,
  output logic           sel_valid,
  output logic [IW-1:0]  sel_in,
  output logic [IW-1:0]  sel_out,
  output logic [IW-1:0]  sel_step,
  output logic           done
);
  localparam int NN  = N * N;
  localparam int CW  = $clog2(N + 1);
  localparam int LCM = gms_pkg::lcm_upto(N);
  localparam int RW  = $clog2(LCM + 1);
  localparam int WW  = RW + 1;

  logic           busy;
  logic [NN-1:0]  remain;
  logic [CW-1:0]  step_cnt;
  logic [CW-1:0]  row_cnt [N];
  logic [CW-1:0]  col_cnt [N];
  logic [WW-1:0]  wgt     [NN];
  logic           pick_found;
  logic [IW-1:0]  pick_row;
  logic [IW-1:0]  pick_col;
  logic [NN-1:0]  clear_mask;
  logic           run_step;
  logic           run_end;

  gms_occupancy #(.N(N), .CW(CW)) u_occ (
    .mtx     (remain),
    .row_cnt (row_cnt),
    .col_cnt (col_cnt)
  );

  gms_weight_array #(.N(N), .CW(CW), .LCM(LCM), .RW(RW), .WW(WW)) u_wgt (
    .clk     (clk),
    .rst_n   (rst_n),
    .mtx     (remain),
    .row_cnt (row_cnt),
    .col_cnt (col_cnt),
    .wgt     (wgt)
  );

  gms_argmax #(.N(N), .IW(IW), .WW(WW)) u_max (
    .clk      (clk),
    .rst_n    (rst_n),
    .wgt      (wgt),
    .found    (pick_found),
    .best_row (pick_row),
    .best_col (pick_col)
  );

  // Every cell sharing the picked row or column is struck out.
  always_comb begin
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        clear_mask[i*N+j] = (IW'(i) == pick_row) || (IW'(j) == pick_col);
      end
    end
  end

  assign run_step = busy && pick_found;
  assign run_end  = busy && !pick_found;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      remain    <= '0;
      step_cnt  <= '0;
      sel_valid <= 1'b0;
      sel_in    <= '0;
      sel_out   <= '0;
      sel_step  <= '0;
      done      <= 1'b0;
    end else begin
      sel_valid <= 1'b0;
      done      <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy     <= 1'b1;
          remain   <= req_mtx;
          step_cnt <= '0;
        end
      end else if (run_step) begin
        sel_valid <= 1'b1;
        sel_in    <= pick_row;
        sel_out   <= pick_col;
        sel_step  <= IW'(step_cnt);
        step_cnt  <= step_cnt + 1'b1;
        remain    <= remain & ~clear_mask;
      end else if (run_end) begin
        done <= 1'b1;
        busy <= 1'b0;
      end
    end
  end

  assert_pick_is_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
    run_step |-> remain[pick_row*N + pick_col]);
  assert_lines_removed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sel_valid |-> (row_cnt[sel_in] == '0 && col_cnt[sel_out] == '0));
  assert_steps_bounded_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (step_cnt <= CW'(N)));
  assert_done_after_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (remain == '0 && !busy));
  assert_done_not_with_pick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_valid && done));
  assert_done_single_cycle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_capture_only_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !pick_found) |=> !busy);
endmodule

// File: tb/tb_greedy_match_sched.sv
module tb_greedy_match_sched;
  localparam int N  = 4;
  localparam int NN = N * N;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [NN-1:0] req_mtx = '0;
  logic          sel_valid;
  logic [IW-1:0] sel_in;
  logic [IW-1:0] sel_out;
  logic [IW-1:0] sel_step;
  logic          done;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  int exp_r [N];
  int exp_c [N];
  int exp_n;
  int obs_r [N];
  int obs_c [N];
  int obs_n;

  always #4 clk = ~clk;

  greedy_match_sched #(.N(N)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_mtx(req_mtx),
    .sel_valid(sel_valid), .sel_in(sel_in), .sel_out(sel_out),
    .sel_step(sel_step), .done(done)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Reference: weight ~ (r+c)/(r*c); compared by cross-multiplication.
  function automatic void model(input logic [NN-1:0] m);
    logic [NN-1:0] rem;
    int rs [N];
    int cs [N];
    int br;
    int bc;
    bit any;
    rem   = m;
    exp_n = 0;
    forever begin
      for (int i = 0; i < N; i++) begin rs[i] = 0; cs[i] = 0; end
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          if (rem[i*N+j]) begin rs[i]++; cs[j]++; end
      any = 0; br = 0; bc = 0;
      for (int i = 0; i < N; i++)
        for (int j = 0; j < N; j++)
          if (rem[i*N+j]) begin
            if (!any || (rs[i]+cs[j])*rs[br]*cs[bc] > (rs[br]+cs[bc])*rs[i]*cs[j]) begin
              any = 1; br = i; bc = j;
            end
          end
      if (!any) break;
      exp_r[exp_n] = br;
      exp_c[exp_n] = bc;
      exp_n++;
      for (int k = 0; k < N; k++) begin
        rem[br*N+k] = 1'b0;
        rem[k*N+bc] = 1'b0;
      end
    end
  endfunction

  task automatic run_case(input logic [NN-1:0] m, input bit poke);
    bit used_r [N];
    bit used_c [N];
    bit dup;
    bit maximal;
    model(m);
    obs_n = 0;
    @(negedge clk);
    req_mtx = m;
    start   = 1'b1;
    @(negedge clk);
    start   = 1'b0;
    req_mtx = ~m;
    for (int k = 0; k <= exp_n; k++) begin
      if (poke && k == 0) begin start = 1'b1; req_mtx = '1; end
      @(negedge clk);
      start = 1'b0;
      if (k < exp_n) begin
        check(sel_valid === 1'b1, "R5 valid", int'(sel_valid), 1);
        check(sel_in == IW'(exp_r[k]) && sel_out == IW'(exp_c[k]), poke ? "R8 pair" : "R3 pair",
              int'(sel_in)*N + int'(sel_out), exp_r[k]*N + exp_c[k]);
        check(sel_step == IW'(k) && done === 1'b0, "R5 step", int'(sel_step), k);
        if (obs_n < N) begin
          obs_r[obs_n] = int'(sel_in);
          obs_c[obs_n] = int'(sel_out);
          obs_n++;
        end
      end else begin
        check(sel_valid === 1'b0 && done === 1'b1, "R6 done", int'({sel_valid, done}), 1);
      end
    end
    @(negedge clk);
    check(sel_valid === 1'b0 && done === 1'b0, "R6 pulse", int'({sel_valid, done}), 0);
    for (int i = 0; i < N; i++) begin used_r[i] = 0; used_c[i] = 0; end
    dup = 0;
    for (int k = 0; k < obs_n; k++) begin
      if (used_r[obs_r[k]] || used_c[obs_c[k]]) dup = 1;
      used_r[obs_r[k]] = 1;
      used_c[obs_c[k]] = 1;
    end
    maximal = 1;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (m[i*N+j] && !used_r[i] && !used_c[j]) maximal = 0;
    check(!dup && maximal, "R7 matching", int'({dup, maximal}), 1);
  endtask

  initial begin
    int wd = 0;
    while (wd < 150000 && !finished) begin
      @(posedge clk);
      wd++;
    end
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 0);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [NN-1:0] m;
    void'($urandom(32'h5EED_1234));
    #3;
    check(sel_valid === 1'b0 && done === 1'b0, "R9 reset", int'({sel_valid, done}), 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(sel_valid === 1'b0 && done === 1'b0, "R9 idle", int'({sel_valid, done}), 0);

    // R10: worked example, then the starved-request case.
    run_case(16'h5816, 1'b0);
    check(obs_n == 4 && obs_r[0] == 2 && obs_c[0] == 3 && obs_r[1] == 0 && obs_c[1] == 1 &&
          obs_r[2] == 1 && obs_c[2] == 0 && obs_r[3] == 3 && obs_c[3] == 2,
          "R10 example", obs_n, 4);
    run_case(16'h0031, 1'b0);
    check(obs_n == 2 && obs_r[0] == 0 && obs_c[0] == 0 && obs_r[1] == 1 && obs_c[1] == 1,
          "R10 starve", obs_n, 2);
    // R4: all weights equal, diagonal order.
    run_case(16'hFFFF, 1'b0);
    check(obs_n == 4 && obs_r[0] == 0 && obs_c[0] == 0 && obs_r[3] == 3 && obs_c[3] == 3,
          "R4 ties", obs_n, 4);
    // R6: empty matrix.
    run_case(16'h0000, 1'b0);
    check(obs_n == 0, "R6 empty", obs_n, 0);
    // R1: single request at input 1, output 3 (bit 7).
    run_case(16'h0080, 1'b0);
    check(obs_n == 1 && obs_r[0] == 1 && obs_c[0] == 3, "R1 encoding", obs_r[0]*N + obs_c[0], 7);
    // R8: start pulsed during busy runs.
    run_case(16'h5816, 1'b1);
    run_case(16'h0000, 1'b1);

    // R2: random matrices of several densities against the model.
    for (int t = 0; t < 300; t++) begin
      case (t % 3)
        0: m = NN'($urandom);
        1: m = NN'($urandom & $urandom);
        default: m = NN'($urandom | $urandom);
      endcase
      run_case(m, (t % 17) == 5);
    end

    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule